// File: doc/BRIEF.md
# Event Status Unit

This unit keeps an 8-bit register of latched instrument events and an 8-bit enable mask, and derives one registered summary flag from them. Other logic in the instrument reports a malformed command, a command that could not execute, a device fault, a query failure or the completion of pending work. Each report is a single-cycle pulse. The pulse sets its bit, and the bit stays set until a host clears it.

A host reads the event register through a strobe. The read returns the current contents and clears the register on the same clock edge. The host can also write and read back the enable mask, and it can issue a clear-status strobe that clears the events but leaves the mask as it is. An asynchronous active-low power-on reset clears the mask and loads the event register with only its power-on bit set. The summary output is high when any set event bit is also enabled. A status-byte stage downstream consumes this flag.

Top module: `event_status_unit`

## Requirements
- R1: While power-on reset is active and after it is released, the event register reads 0x80 (only bit 7 set), the enable mask reads 0x00 and the summary output is 0.
- R2: A pulse on an event input sets its bit, visible on the cycle after the edge that samples it. The bit for each input is: command error bit 5, execution error bit 4, device fault bit 3, query failure bit 2, operation complete bit 0.
- R3: A set event bit stays set, whatever its input does, until a read strobe or a clear-status strobe is sampled.
- R4: Bits 6 and 1 of the event register always read 0. With every event input pulsed at once, the register holds 0x3D.
- R5: In the cycle where the read strobe is high, the read data shows the current register. At that edge every bit is cleared, bit 7 included.
- R6: The clear-status strobe clears the event register and leaves the enable mask unchanged.
- R7: A mask write stores any value from 0x00 to 0xFF, and that value reads back from the next cycle on.
- R8: The summary output equals the OR of (event register AND enable mask) as it stood one cycle earlier. A mask of 0x00 forces it to 0 on the next cycle.
- R9: An event pulse sampled on the same edge as a read strobe or a clear-status strobe leaves its bit set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cmd_err_i | input | 1 | Command error pulse |
| exe_err_i | input | 1 | Execution error pulse |
| dev_err_i | input | 1 | Device fault pulse |
| qry_err_i | input | 1 | Query failure pulse |
| op_done_i | input | 1 | Operation complete pulse |
| evt_rd_i | input | 1 | Read strobe; clears the event register at the edge |
| clr_stat_i | input | 1 | Clear-status strobe |
| evt_rdata_o | output | 8 | Current event register contents |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write data |
| mask_o | output | 8 | Current enable mask |
| summary_o | output | 1 | Registered summary flag |

## Verification
Two things can fall on the same edge: an event pulse, and a clear from either the read strobe or the clear-status strobe. The correct outcome is that the pulsed bit survives while every other bit is cleared. The bench forces this collision in directed steps, pairing one pulse with a read and another with a clear-status. Random stimulus then produces the collision many times over, mixed with mask writes. Each cycle the bench compares the register, the mask and the one-cycle-late summary against a next-state model built from the requirements.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EVT_W   = 8;
  localparam int PWR_BIT = 7;
  localparam int CMD_BIT = 5;
  localparam int EXE_BIT = 4;
  localparam int DEV_BIT = 3;
  localparam int QRY_BIT = 2;
  localparam int OPC_BIT = 0;

  // bits that can ever hold a 1
  localparam logic [EVT_W-1:0] LIVE_BITS =
    EVT_W'((1 << PWR_BIT) | (1 << CMD_BIT) | (1 << EXE_BIT) |
           (1 << DEV_BIT) | (1 << QRY_BIT) | (1 << OPC_BIT));
  localparam logic [EVT_W-1:0] PWR_INIT = EVT_W'(1 << PWR_BIT);

  typedef struct packed {
    logic cmd;
    logic exe;
    logic dev;
    logic qry;
    logic opc;
  } evt_pulse_t;

  function automatic logic [EVT_W-1:0] pulse_to_vec(evt_pulse_t p);
    logic [EVT_W-1:0] v;
    v          = '0;
    v[CMD_BIT] = p.cmd;
    v[EXE_BIT] = p.exe;
    v[DEV_BIT] = p.dev;
    v[QRY_BIT] = p.qry;
    v[OPC_BIT] = p.opc;
    return v;
  endfunction
endpackage

// File: rtl/evs_event_reg.sv
module evs_event_reg #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     LIVE = '1,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q, bit_d;
    // set wins over clear so a coincident event is kept
    assign bit_d = LIVE[i] & (set_i[i] | (bit_q & ~clr_i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= INIT[i];
      else         bit_q <= bit_d;
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/evs_mask_reg.sv
module evs_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/evs_summary.sv
module evs_summary #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  output logic         sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= 1'b0;
    else         sum_o <= |(evt_i & mask_i);
  end
endmodule

// File: rtl/event_status_unit.sv
module event_status_unit
  import evs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_err_i,
  input  logic             exe_err_i,
  input  logic             dev_err_i,
  input  logic             qry_err_i,
  input  logic             op_done_i,
  input  logic             evt_rd_i,
  input  logic             clr_stat_i,
  output logic [EVT_W-1:0] evt_rdata_o,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_wdata_i,
  output logic [EVT_W-1:0] mask_o,
  output logic             summary_o
);
  evt_pulse_t       pulses;
  logic [EVT_W-1:0] set_vec;
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] mask_q;
  logic             evt_clr;

  assign pulses  = '{cmd: cmd_err_i, exe: exe_err_i, dev: dev_err_i,
                     qry: qry_err_i, opc: op_done_i};
  assign set_vec = pulse_to_vec(pulses);
  assign evt_clr = evt_rd_i | clr_stat_i;

  evs_event_reg #(
    .W    (EVT_W),
    .LIVE (LIVE_BITS),
    .INIT (PWR_INIT)
  ) i_event_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (evt_clr),
    .q_o    (evt_q)
  );

  evs_mask_reg #(
    .W (EVT_W)
  ) i_mask_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .q_o     (mask_q)
  );

  evs_summary #(
    .W (EVT_W)
  ) i_summary (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_q),
    .mask_i (mask_q),
    .sum_o  (summary_o)
  );

  assign evt_rdata_o = evt_q;
  assign mask_o      = mask_q;
endmodule

// File: rtl/evs_chk.sv
module evs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_err_i,
  input logic       exe_err_i,
  input logic       dev_err_i,
  input logic       qry_err_i,
  input logic       op_done_i,
  input logic       evt_rd_i,
  input logic       clr_stat_i,
  input logic [7:0] evt_rdata_o,
  input logic       mask_we_i,
  input logic [7:0] mask_wdata_i,
  input logic [7:0] mask_o,
  input logic       summary_o
);
  logic any_pulse;
  assign any_pulse = cmd_err_i | exe_err_i | dev_err_i | qry_err_i | op_done_i;

  // R2
  cmd_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_i |=> evt_rdata_o[5]);
  // R2
  opc_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |=> evt_rdata_o[0]);
  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_rd_i && !clr_stat_i) |=>
      ((evt_rdata_o & $past(evt_rdata_o)) == $past(evt_rdata_o)));
  // R4
  dead_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rdata_o[6] == 1'b0) && (evt_rdata_o[1] == 1'b0));
  // R5
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd_i && !any_pulse) |=> (evt_rdata_o == 8'h00));
  // R6
  clr_keeps_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stat_i && !mask_we_i) |=> $stable(mask_o));
  // R7
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));
  // R8
  summary_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (summary_o == |($past(evt_rdata_o) & $past(mask_o))));
  // R9
  cmd_survives_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_err_i && (evt_rd_i || clr_stat_i)) |=> evt_rdata_o[5]);
endmodule

bind event_status_unit evs_chk i_evs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_err_i    (cmd_err_i),
  .exe_err_i    (exe_err_i),
  .dev_err_i    (dev_err_i),
  .qry_err_i    (qry_err_i),
  .op_done_i    (op_done_i),
  .evt_rd_i     (evt_rd_i),
  .clr_stat_i   (clr_stat_i),
  .evt_rdata_o  (evt_rdata_o),
  .mask_we_i    (mask_we_i),
  .mask_wdata_i (mask_wdata_i),
  .mask_o       (mask_o),
  .summary_o    (summary_o)
);

// File: tb/test_event_status_unit.sv
module test_event_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_err_i = 0, exe_err_i = 0, dev_err_i = 0, qry_err_i = 0, op_done_i = 0;
  logic       evt_rd_i = 0, clr_stat_i = 0, mask_we_i = 0;
  logic [7:0] mask_wdata_i = '0;
  logic [7:0] evt_rdata_o, mask_o;
  logic       summary_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] evt_m = 8'h80, mask_m = 8'h00;
  logic       sum_m = 1'b0;

  always #2 clk_i = ~clk_i;

  event_status_unit i_event_status_unit (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R2/R4: bit map and live bits stated in the requirements
  function automatic logic [7:0] next_evt(logic [7:0] cur, logic [4:0] p, logic clr);
    logic [7:0] s;
    s = {2'b00, p[4], p[3], p[2], p[1], 1'b0, p[0]}; // cmd,exe,dev,qry,-,opc
    return ((clr ? 8'h00 : cur) | s) & 8'hBD;
  endfunction

  task automatic check_all(string e_tag, string m_tag, string s_tag);
    chk(e_tag, evt_rdata_o, evt_m);
    chk(m_tag, mask_o, mask_m);
    chk(s_tag, {7'd0, summary_o}, {7'd0, sum_m});
  endtask

  // p = {cmd,exe,dev,qry,opc}; called at a falling edge, returns at the next one
  task automatic step(logic [4:0] p, logic rd, logic cs, logic we, logic [7:0] wd);
    {cmd_err_i, exe_err_i, dev_err_i, qry_err_i, op_done_i} = p;
    evt_rd_i = rd; clr_stat_i = cs; mask_we_i = we; mask_wdata_i = wd;
    if (rd) chk("R5 read data", evt_rdata_o, evt_m);
    sum_m  = |(evt_m & mask_m);
    evt_m  = next_evt(evt_m, p, rd | cs);
    if (we) mask_m = wd;
    @(negedge clk_i);
    {cmd_err_i, exe_err_i, dev_err_i, qry_err_i, op_done_i} = '0;
    evt_rd_i = 0; clr_stat_i = 0; mask_we_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(5'b0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7177));
    @(negedge clk_i);
    check_all("R1", "R1", "R1");           // during reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1", "R1", "R1");

    step(5'b0, 0, 0, 1, 8'hFF);            // R7 mask write
    check_all("R3", "R7", "R8");
    idle(1);
    check_all("R3", "R7", "R8 power bit enabled");
    chk("R8", {7'd0, summary_o}, 8'h01);
    step(5'b0, 1, 0, 0, 8'h00);            // R5 read clears bit 7
    chk("R5", evt_rdata_o, 8'h00);
    idle(1);
    chk("R8 after clear", {7'd0, summary_o}, 8'h00);

    // R2 each input on its own, then R3 hold
    for (int b = 0; b < 5; b++) begin
      step(5'(1 << b), 0, 0, 0, 8'h00);
      check_all("R2", "R7", "R8");
      idle(3);
      check_all("R3", "R7", "R8");
      step(5'b0, 1, 0, 0, 8'h00);
      check_all("R5", "R7", "R8");
    end

    step(5'b11111, 0, 0, 0, 8'h00);        // R4 all at once
    chk("R4", evt_rdata_o, 8'h3D);
    idle(1);
    step(5'b0, 0, 1, 0, 8'h00);            // R6 clear-status
    chk("R6 events", evt_rdata_o, 8'h00);
    chk("R6 mask", mask_o, 8'hFF);

    step(5'b10000, 1, 0, 0, 8'h00);        // R9 cmd with read
    chk("R9 read", evt_rdata_o, 8'h20);
    step(5'b01000, 0, 1, 0, 8'h00);        // R9 exe with clear-status
    chk("R9 clear", evt_rdata_o, 8'h10);

    step(5'b0, 0, 0, 1, 8'h00);            // R8 mask zero
    idle(1);
    chk("R8 mask zero", {7'd0, summary_o}, 8'h00);
    step(5'b0, 0, 0, 1, 8'h10);
    idle(1);
    chk("R8 one enabled", {7'd0, summary_o}, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] p;
      for (int k = 0; k < 5; k++) p[k] = ($urandom % 5) == 0;
      step(p, ($urandom % 8) == 0, ($urandom % 16) == 0,
           ($urandom % 6) == 0, 8'($urandom));
      check_all("R3", "R7", "R8");
      chk("R4 dead bits", evt_rdata_o & 8'h42, 8'h00);
    end

    rst_ni = 1'b0;                          // R1 power-on mid-run
    evt_m = 8'h80; mask_m = 8'h00; sum_m = 1'b0;
    @(negedge clk_i);
    check_all("R1", "R1", "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1", "R1", "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule